// File: doc/BRIEF.md
# Element Loop Sequencer with Data-Dependent Early Exit

This block sits between instruction issue and decode and turns one vectorised scalar operation into a hardware for-loop over its elements. A start pulse brings in the element count and the loop options. While the loop runs, the block holds the main program counter. It offers the operation to execution once for each element and tags each offer with an element index. That index counts up from zero, or down from the last element when reverse mode is set. Looping adds no extra cycles beyond the element handshakes.

Each offered element uses a valid/ready handshake. The sequencer raises `elem_valid` with a stable `elem_idx` and keeps both until `elem_ready` is seen high on a rising edge. Only one element may be in flight. The next element is offered only after execution returns a completion pulse (`cmp_valid`) with a per-element test result (`cmp_fail`).

With early exit enabled, the first element whose test fails ends the loop. The resulting length is cut at that element. An option chooses whether the failing element is counted in that length. When the loop ends, a one-cycle `done` pulse is raised, the program counter is released, and the resulting length appears on `vl_out`.

Top module: `elem_loop_seq`

## Requirements
- R1: `pc_hold` is high from the cycle after an accepted start until the loop finishes. It is low in the cycle `done` is high and whenever the block is idle.
- R2: At most one element is outstanding. While `elem_valid` is high and `elem_ready` is low, `elem_valid` and `elem_idx` hold. After an element is accepted, no new element is offered until `cmp_valid` is seen.
- R3: In forward mode (`reverse`=0), elements are offered with indices 0, 1, …, VL-1 in that order.
- R4: In reverse mode (`reverse`=1), elements are offered with indices VL-1, VL-2, …, 0 in that order.
- R5: With early exit enabled (`ffirst_en`=1), a completion with `cmp_fail`=1 ends the loop. No further element is offered.
- R6: With early exit and `ffirst_incl`=1, a failure at the i-th completed element (i counted from 0 in issue order, for either direction) gives `vl_out` = i+1.
- R7: With early exit and `ffirst_incl`=0, the same failure gives `vl_out` = i.
- R8: With `ffirst_en`=0, `cmp_fail` has no effect. All VL elements are offered and `vl_out` equals the VL given at start.
- R9: A start with VL=0 offers no element, raises `done` in the following cycle and gives `vl_out`=0.
- R10: `done` is a one-cycle pulse on the cycle after the finishing completion. `vl_out` changes only in that cycle and is otherwise stable. A start pulse while a loop is running is ignored, and so is any change of `vl_in` during the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop; sampled only while idle |
| vl_in | input | VL_W | Element count for the loop |
| reverse | input | 1 | 1 = run indices downward |
| ffirst_en | input | 1 | Enable data-dependent early exit |
| ffirst_incl | input | 1 | 1 = count the failing element in the result length |
| elem_valid | output | 1 | Element offered to execution |
| elem_ready | input | 1 | Execution accepts the offered element |
| elem_idx | output | VL_W | Index of the offered element |
| cmp_valid | input | 1 | Completion of the outstanding element |
| cmp_fail | input | 1 | Test result of the completed element |
| pc_hold | output | 1 | Keep the main program counter paused |
| vl_out | output | VL_W | Resulting (possibly shortened) length |
| done | output | 1 | One-cycle loop-finished pulse |

## Verification
The bench builds the block with VL_W=5, so lengths reach 31. This lets it cover a full-length reverse loop whose last element fails, as well as the empty loop. The small width keeps every run short enough to check the index on every offered element. It also reaches an element held under back-pressure, a start pulse and a changed length during a busy loop, and failures at the first, middle and last element in both directions.

// File: rtl/elem_loop_pkg.sv
package elem_loop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/elem_idx_gen.sv
// Element index and issue-order counter; direction picked at load.
module elem_idx_gen #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            reverse_in,
  input  logic [VL_W-1:0] vl_in,
  output logic [VL_W-1:0] idx_o,
  output logic [VL_W-1:0] cnt_o,
  output logic [VL_W-1:0] vl_lat_o,
  output logic            last_o
);
  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  logic rev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o    <= '0;
      cnt_o    <= '0;
      vl_lat_o <= '0;
      rev_q    <= 1'b0;
    end else if (load) begin
      cnt_o    <= '0;
      vl_lat_o <= vl_in;
      rev_q    <= reverse_in;
      idx_o    <= reverse_in ? (vl_in - ONE) : '0;
    end else if (step) begin
      cnt_o <= cnt_o + ONE;
      idx_o <= rev_q ? (idx_o - ONE) : (idx_o + ONE);
    end
  end

  assign last_o = (cnt_o == (vl_lat_o - ONE));
endmodule

// File: rtl/elem_trunc.sv
// Decides whether a completion ends the loop and what length results.
module elem_trunc #(
  parameter int VL_W = 7
) (
  input  logic            ff_en,
  input  logic            ff_incl,
  input  logic            fail,
  input  logic            last,
  input  logic [VL_W-1:0] cnt,
  input  logic [VL_W-1:0] vl_lat,
  output logic            stop,
  output logic [VL_W-1:0] len
);
  localparam logic [VL_W-1:0] ONE = VL_W'(1);

  logic hit;

  always_comb begin
    hit  = ff_en & fail;
    stop = hit | last;
    if (hit) len = ff_incl ? (cnt + ONE) : cnt;
    else     len = vl_lat;
  end
endmodule

// File: rtl/elem_loop_ctrl.sv
// Loop state machine: start capture, issue handshake, completion, finish.
module elem_loop_ctrl
  import elem_loop_pkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  logic            ffirst_en,
  input  logic            ffirst_incl,
  input  logic            elem_ready,
  input  logic            cmp_valid,
  input  logic            stop,
  input  logic [VL_W-1:0] len,
  output logic            load,
  output logic            step,
  output logic            ff_en_q,
  output logic            ff_incl_q,
  output logic            elem_valid,
  output logic            pc_hold,
  output logic [VL_W-1:0] vl_out,
  output logic            done
);
  seq_state_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      vl_out    <= '0;
      ff_en_q   <= 1'b0;
      ff_incl_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          ff_en_q   <= ffirst_en;
          ff_incl_q <= ffirst_incl;
          if (vl_in == '0) begin
            done   <= 1'b1;
            vl_out <= '0;
          end else begin
            st <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (elem_ready) st <= ST_WAIT;
        ST_WAIT: if (cmp_valid) begin
          if (stop) begin
            st     <= ST_IDLE;
            done   <= 1'b1;
            vl_out <= len;
          end else begin
            st <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign load       = (st == ST_IDLE) & start;
  assign step       = (st == ST_WAIT) & cmp_valid & ~stop;
  assign elem_valid = (st == ST_ISSUE);
  assign pc_hold    = (st != ST_IDLE);
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq #(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VL_W-1:0] vl_in,
  input  logic            reverse,
  input  logic            ffirst_en,
  input  logic            ffirst_incl,
  output logic            elem_valid,
  input  logic            elem_ready,
  output logic [VL_W-1:0] elem_idx,
  input  logic            cmp_valid,
  input  logic            cmp_fail,
  output logic            pc_hold,
  output logic [VL_W-1:0] vl_out,
  output logic            done
);
  logic            load, step, stop, last, ff_en_q, ff_incl_q;
  logic [VL_W-1:0] cnt, vl_lat, len;

  elem_loop_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .ffirst_en(ffirst_en), .ffirst_incl(ffirst_incl),
    .elem_ready(elem_ready), .cmp_valid(cmp_valid),
    .stop(stop), .len(len), .load(load), .step(step),
    .ff_en_q(ff_en_q), .ff_incl_q(ff_incl_q),
    .elem_valid(elem_valid), .pc_hold(pc_hold),
    .vl_out(vl_out), .done(done)
  );

  elem_idx_gen #(.VL_W(VL_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .reverse_in(reverse), .vl_in(vl_in), .idx_o(elem_idx),
    .cnt_o(cnt), .vl_lat_o(vl_lat), .last_o(last)
  );

  elem_trunc #(.VL_W(VL_W)) u_trunc (
    .ff_en(ff_en_q), .ff_incl(ff_incl_q), .fail(cmp_fail), .last(last),
    .cnt(cnt), .vl_lat(vl_lat), .stop(stop), .len(len)
  );
endmodule

// File: rtl/elem_loop_seq_chk.sv
module elem_loop_seq_chk #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            elem_valid,
  input logic            elem_ready,
  input logic [VL_W-1:0] elem_idx,
  input logic            pc_hold,
  input logic [VL_W-1:0] vl_out,
  input logic            done
);
  assert_hold_while_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> pc_hold);

  assert_release_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pc_hold);

  assert_offer_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !elem_ready) |=> (elem_valid && $stable(elem_idx)));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && elem_ready) |=> !elem_valid);

  assert_len_only_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vl_out) |-> done);

  assert_no_offer_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !elem_valid);
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.VL_W(VL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .elem_ready(elem_ready),
  .elem_idx(elem_idx), .pc_hold(pc_hold), .vl_out(vl_out), .done(done)
);

// File: tb/elem_loop_seq_tb.sv
`timescale 1ns/1ps
module elem_loop_seq_tb;
  localparam int VL_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [VL_W-1:0] vl_in = '0;
  logic            reverse = 1'b0;
  logic            ffirst_en = 1'b0;
  logic            ffirst_incl = 1'b0;
  logic            elem_ready = 1'b0;
  logic            cmp_valid = 1'b0;
  logic            cmp_fail = 1'b0;
  logic            elem_valid, pc_hold, done;
  logic [VL_W-1:0] elem_idx, vl_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  elem_loop_seq #(.VL_W(VL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in), .reverse(reverse),
    .ffirst_en(ffirst_en), .ffirst_incl(ffirst_incl), .elem_valid(elem_valid),
    .elem_ready(elem_ready), .elem_idx(elem_idx), .cmp_valid(cmp_valid),
    .cmp_fail(cmp_fail), .pc_hold(pc_hold), .vl_out(vl_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One loop run. fail_at: issue position whose test fails (-1 = none).
  task automatic run_loop(input int vl, input bit rev, input bit ff, input bit incl,
                          input int fail_at, input bit stall, input bit poke);
    int issued = 0;
    int guard = 0;
    int exp_len, exp_cnt, exp_idx;
    logic [VL_W-1:0] held;
    bit hit = ff && fail_at >= 0 && fail_at < vl;
    exp_len = hit ? (incl ? fail_at + 1 : fail_at) : vl;
    exp_cnt = hit ? fail_at + 1 : vl;
    @(negedge clk);
    start = 1'b1; vl_in = VL_W'(vl); reverse = rev; ffirst_en = ff; ffirst_incl = incl;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 2000) begin
      guard++;
      if (elem_valid) begin
        exp_idx = rev ? vl - 1 - issued : issued;
        check(elem_idx == VL_W'(exp_idx), rev ? "R4 index order" : "R3 index order",
              int'(elem_idx), exp_idx);
        check(pc_hold == 1'b1, "R1 hold during loop", int'(pc_hold), 1);
        if (stall && issued == 0) begin
          held = elem_idx;
          @(negedge clk);
          check(elem_valid && elem_idx == held, "R2 offer held under back-pressure",
                int'(elem_idx), int'(held));
        end
        elem_ready = 1'b1;
        @(negedge clk);
        elem_ready = 1'b0;
        check(!elem_valid, "R2 single outstanding", int'(elem_valid), 0);
        if (poke && issued == 1) begin
          start = 1'b1; vl_in = VL_W'(vl + 3);
          @(negedge clk);
          start = 1'b0;
        end
        cmp_valid = 1'b1;
        cmp_fail = (issued == fail_at);
        @(negedge clk);
        cmp_valid = 1'b0; cmp_fail = 1'b0;
        issued++;
      end else begin
        @(negedge clk);
      end
    end
    check(done == 1'b1, "R10 done raised", int'(done), 1);
    check(issued == exp_cnt, hit ? "R5 elements issued before exit" :
          (ff ? "R8 all elements issued" : "R8 all elements issued"), issued, exp_cnt);
    check(int'(vl_out) == exp_len, hit ? (incl ? "R6 length incl" : "R7 length excl") :
          (vl == 0 ? "R9 empty length" : "R8 full length"), int'(vl_out), exp_len);
    check(!pc_hold, "R1 released at done", int'(pc_hold), 0);
    @(negedge clk);
    check(!done, "R10 done single pulse", int'(done), 0);
    repeat (3) @(negedge clk);
    check(int'(vl_out) == exp_len && !elem_valid, "R10 length stable after run",
          int'(vl_out), exp_len);
  endtask

  task automatic test_reset();
    check(!elem_valid && !pc_hold && !done, "R1 reset idle", int'(pc_hold), 0);
    check(vl_out == '0, "R10 reset length", int'(vl_out), 0);
  endtask

  task automatic test_empty();
    @(negedge clk);
    start = 1'b1; vl_in = '0; ffirst_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9 done one cycle after start", int'(done), 1);
    check(!elem_valid && !pc_hold, "R9 nothing issued", int'(elem_valid), 0);
    check(vl_out == '0, "R9 length zero", int'(vl_out), 0);
    @(negedge clk);
    check(!done && !elem_valid, "R9 no late issue", int'(elem_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_loop(4, 0, 0, 0, -1, 0, 0);   // R3 forward
    run_loop(5, 1, 0, 0, -1, 1, 0);   // R4 reverse with stall
    run_loop(6, 0, 0, 1, 2, 0, 0);    // R8 fail ignored
    run_loop(6, 0, 1, 1, 2, 0, 0);    // R5 R6
    run_loop(7, 1, 1, 0, 3, 1, 0);    // R7 reverse
    run_loop(4, 0, 1, 0, 0, 0, 0);    // R7 first element fails
    run_loop(4, 1, 1, 1, 0, 0, 0);    // R6 first element fails
    run_loop(31, 1, 1, 1, 30, 0, 0);  // R6 last element of max length
    run_loop(8, 0, 1, 0, 7, 0, 0);    // R7 last element fails
    test_empty();                     // R9
    run_loop(4, 0, 0, 0, -1, 0, 1);   // R10 start while busy ignored
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule